// File: doc/BRIEF.md
# Glitch-Free System Clock Source Selector

This block picks one of three oscillator clocks to drive the system clock: an internal RC oscillator, a low-speed oscillator or a high-speed oscillator. A 2-bit select input names the wanted source. A control state machine runs on a free-running control clock. It moves the clock only to a source that is both enabled and stable. A request for a source that is not yet ready is held until that source becomes ready.

Each source has a gating branch. A branch synchronises its grant into its own clock domain and opens or closes its gate on that clock's falling edge. The controller closes the old branch fully before it opens the new one, so the system clock never carries a shortened pulse.

For power management, the block reports which source is active. It also gives one permission flag per oscillator, which says when that oscillator may be stopped. The intended low-power flow is to move to the low-speed clock and then stop the high-speed oscillator once its flag is set.

Top module: `clksel_top`

## Requirements
- R1: `active_src` always shows one of three codes: 0 for the internal source, 1 for the low-speed source, 2 for the high-speed source. It never shows 3.
- R2: After reset, `active_src` is 0 and `busy` is low. `sys_clk` runs at the internal oscillator's period, and `off_ok` is 3'b110 while every external-use input is low.
- R3: A select value of 3 is ignored. The active source and any pending request stay as they were.
- R4: A switch to source code k starts only while bit k of both `osc_en` and `osc_stable` is high. Until then the request stays pending, and it completes without a new request once both bits are high.
- R5: Every high phase of `sys_clk` is a complete high phase of one source clock. No shortened pulse appears during a switch.
- R6: Once a switch completes and `busy` is low, `sys_clk` has the period of the newly selected source.
- R7: Bit k of `off_ok` is high only while source k is not the active source, not granted, not gated on, and bit k of `osc_ext_use` is low.
- R8: `active_src` changes only at the end of a switch, and only to the most recent non-reserved select code. It does not change while `busy` has been low for a full cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 3 | Source clocks, indexed by source code (0 internal, 1 low, 2 high) |
| osc_en | input | 3 | Oscillator enable bits, by source code |
| osc_stable | input | 3 | Oscillator stable flags, by source code |
| osc_ext_use | input | 3 | Per-oscillator flag that another user still needs the clock |
| src_sel | input | 2 | Requested source code; 3 is reserved |
| sys_clk | output | 1 | Selected, glitch-free system clock |
| active_src | output | 2 | Code of the source now driving `sys_clk` |
| busy | output | 1 | High while a switch is in progress |
| off_ok | output | 3 | Per-oscillator permission to stop it |

## Verification
The assertions assume four things about the inputs:
- The control clock runs all the time.
- Any oscillator being released keeps toggling until its gate has closed.
- `osc_stable` only rises for an oscillator that is actually toggling.
- `src_sel` is changed only while no switch is in progress.

The stimulus follows these rules. It drives `src_sel`, the enables and the stable flags on the falling control edge, and only while `busy` is low. All three source clocks run free throughout, so a released clock can always finish closing its gate.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
    localparam int NSRC  = 3;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_INT  = 2'd0,
        SRC_LOW  = 2'd1,
        SRC_HIGH = 2'd2,
        SRC_RSV  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DROP  = 2'd1,
        ST_RAISE = 2'd2
    } st_e;

    typedef struct packed {
        st_e             st;
        src_e            req;
        src_e            act;
        src_e            tgt;
        logic [NSRC-1:0] grant;
    } ctl_t;
endpackage

// File: rtl/clksel_sync2.sv
module clksel_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {2{RST_VAL}};
        else        stage_q <= stage_d;
    end

    assign q = stage_q[1];
endmodule

// File: rtl/clksel_branch.sv
module clksel_branch #(
    parameter logic RST_ON = 1'b0
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic grant,
    output logic gated,
    output logic gate_en
);
    logic grant_s;
    logic en_d, en_q;

    // grant crosses into the source domain on rising edges
    clksel_sync2 #(.RST_VAL(RST_ON)) u_sync (
        .clk   (src_clk),
        .rst_n (rst_n),
        .d     (grant),
        .q     (grant_s)
    );

    always_comb begin
        en_d = grant_s;
    end

    // gate changes only while the source clock is low
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) en_q <= RST_ON;
        else        en_q <= en_d;
    end

    assign gated   = src_clk & en_q;
    assign gate_en = en_q;
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int RST_SRC = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [NSRC-1:0]  ready,
    input  logic [NSRC-1:0]  ack,
    input  logic [NSRC-1:0]  ext_use,
    output logic [NSRC-1:0]  grant,
    output logic [SEL_W-1:0] act,
    output logic             busy,
    output logic [NSRC-1:0]  off_ok
);
    localparam src_e            RST_CODE  = src_e'(RST_SRC);
    localparam logic [NSRC-1:0] RST_GRANT = NSRC'(1) << RST_SRC;

    ctl_t d, q;

    always_comb begin
        d = q;
        if (src_e'(sel) != SRC_RSV) d.req = src_e'(sel);
        unique case (q.st)
            ST_IDLE: begin
                if (q.req != q.act && ready[q.req]) begin
                    d.tgt          = q.req;
                    d.grant[q.act] = 1'b0;
                    d.st           = ST_DROP;
                end
            end
            ST_DROP: begin
                if (!ack[q.act]) begin
                    d.grant[q.tgt] = 1'b1;
                    d.st           = ST_RAISE;
                end
            end
            ST_RAISE: begin
                if (ack[q.tgt]) begin
                    d.act = q.tgt;
                    d.st  = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.req   <= RST_CODE;
            q.act   <= RST_CODE;
            q.tgt   <= RST_CODE;
            q.grant <= RST_GRANT;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            off_ok[i] = !ext_use[i] && !q.grant[i] && !ack[i] &&
                        (q.act != src_e'(i));
        end
    end

    assign grant = q.grant;
    assign act   = q.act;
    assign busy  = (q.st != ST_IDLE);
endmodule

// File: rtl/clksel_top.sv
module clksel_top
    import clksel_pkg::*;
#(
    parameter int RST_SRC = 0
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  osc_clk,
    input  logic [NSRC-1:0]  osc_en,
    input  logic [NSRC-1:0]  osc_stable,
    input  logic [NSRC-1:0]  osc_ext_use,
    input  logic [SEL_W-1:0] src_sel,
    output logic             sys_clk,
    output logic [SEL_W-1:0] active_src,
    output logic             busy,
    output logic [NSRC-1:0]  off_ok
);
    logic [NSRC-1:0] ready_s, ack_s, grant_w, gated_w, gate_en_w;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam logic IS_RST = (i == RST_SRC);

        clksel_sync2 #(.RST_VAL(1'b0)) u_ready (
            .clk   (ref_clk),
            .rst_n (rst_n),
            .d     (osc_en[i] & osc_stable[i]),
            .q     (ready_s[i])
        );

        clksel_branch #(.RST_ON(IS_RST)) u_branch (
            .src_clk (osc_clk[i]),
            .rst_n   (rst_n),
            .grant   (grant_w[i]),
            .gated   (gated_w[i]),
            .gate_en (gate_en_w[i])
        );

        clksel_sync2 #(.RST_VAL(IS_RST)) u_ack (
            .clk   (ref_clk),
            .rst_n (rst_n),
            .d     (gate_en_w[i]),
            .q     (ack_s[i])
        );
    end

    clksel_ctrl #(.RST_SRC(RST_SRC)) u_ctrl (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .sel     (src_sel),
        .ready   (ready_s),
        .ack     (ack_s),
        .ext_use (osc_ext_use),
        .grant   (grant_w),
        .act     (active_src),
        .busy    (busy),
        .off_ok  (off_ok)
    );

    assign sys_clk = |gated_w;
endmodule

// File: rtl/clksel_chk.sv
module clksel_chk
    import clksel_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] sel,
    input logic [NSRC-1:0]  ready,
    input logic [NSRC-1:0]  ack,
    input logic [NSRC-1:0]  ext_use,
    input logic [NSRC-1:0]  grant,
    input logic [SEL_W-1:0] act,
    input logic             busy,
    input logic [NSRC-1:0]  off_ok,
    input logic [SEL_W-1:0] tgt
);
    logic [NSRC-1:0] ready_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ready_q <= '0;
        else        ready_q <= ready;
    end

    p_code_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        act != 2'd3);

    p_reserved_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd3 && !busy) |=> $stable(act));

    p_start_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> ready_q[tgt]);

    p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_one_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));

    p_off_rule_r7: assert property (@(posedge clk) disable iff (!rst_n)
        off_ok[act] == 1'b0 && (off_ok & ext_use) == '0);

    p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(act));
endmodule

bind clksel_ctrl clksel_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .ready   (ready),
    .ack     (ack),
    .ext_use (ext_use),
    .grant   (grant),
    .act     (act),
    .busy    (busy),
    .off_ok  (off_ok),
    .tgt     (q.tgt)
);

// File: tb/clksel_top_test.sv
`timescale 1ns/1ps
module clksel_top_test;
    localparam real CLK_PERIOD = 10.0;
    localparam real P_INT  = 14.0;
    localparam real P_LOW  = 62.0;
    localparam real P_HIGH = 6.0;
    localparam int  WD_LIMIT = 150000;

    logic       ref_clk = 0, rst_n = 0;
    logic [2:0] osc_clk = '0, osc_en = 3'b001, osc_stable = 3'b001, osc_ext_use = '0;
    logic [1:0] src_sel = 2'd0;
    logic       sys_clk, busy;
    logic [1:0] active_src;
    logic [2:0] off_ok;

    int tests = 0, fails = 0, cycles = 0;
    int model_req = 0;
    int prev_act = 0;
    real t_rise = -1.0;

    clksel_top uut (
        .ref_clk(ref_clk), .rst_n(rst_n), .osc_clk(osc_clk), .osc_en(osc_en),
        .osc_stable(osc_stable), .osc_ext_use(osc_ext_use), .src_sel(src_sel),
        .sys_clk(sys_clk), .active_src(active_src), .busy(busy), .off_ok(off_ok)
    );

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
    always #(P_INT/2)      osc_clk[0] = ~osc_clk[0];
    always #(P_LOW/2)      osc_clk[1] = ~osc_clk[1];
    always #(P_HIGH/2)     osc_clk[2] = ~osc_clk[2];

    task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
        end
    endtask

    function automatic bit near(input real a, input real b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    // R5: every high phase must be a full source high phase
    always @(posedge sys_clk) t_rise = $realtime;
    always @(negedge sys_clk) begin
        if (rst_n && t_rise >= 0.0) begin
            real w;
            w = $realtime - t_rise;
            check(near(w, P_INT/2) || near(w, P_LOW/2) || near(w, P_HIGH/2),
                  "R5 high phase width (ps)", int'(w*1000), int'(P_HIGH*500));
        end
    end

    // per-cycle comparison against the behavioural model
    always @(negedge ref_clk) begin
        cycles++;
        if (rst_n) begin
            check(active_src != 2'd3, "R1 code valid", active_src, model_req);
            if (int'(active_src) != prev_act)
                check(int'(active_src) == model_req, "R8 change to request", active_src, model_req);
            for (int i = 0; i < 3; i++)
                if (off_ok[i])
                    check(int'(active_src) != i && !osc_ext_use[i],
                          "R7 off permission", off_ok[i], 0);
            prev_act = int'(active_src);
        end
        if (cycles > WD_LIMIT) begin
            check(0, "watchdog", cycles, WD_LIMIT);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic set_sel(input int code);
        @(negedge ref_clk);
        src_sel = 2'(code);
        if (code != 3) model_req = code;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic wait_active(input int exp_v, input string tag);
        int k = 0;
        while ((int'(active_src) != exp_v || busy) && k < 3000) begin
            @(negedge ref_clk);
            k++;
        end
        check(int'(active_src) == exp_v && !busy, tag, active_src, exp_v);
    endtask

    task automatic check_period(input real exp_p, input string tag);
        real t0, t1;
        @(posedge sys_clk); t0 = $realtime;
        @(posedge sys_clk); t1 = $realtime;
        check(near(t1 - t0, exp_p), tag, int'((t1-t0)*1000), int'(exp_p*1000));
        @(negedge ref_clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(10);
        // R2 reset state
        check(active_src == 2'd0, "R2 reset source", active_src, 0);
        check(!busy, "R2 reset busy", busy, 0);
        check(off_ok == 3'b110, "R2 reset off_ok", off_ok, 6);
        check_period(P_INT, "R2 internal period");

        // R3 reserved code ignored
        set_sel(3);
        idle(200);
        check(active_src == 2'd0 && !busy, "R3 reserved ignored", active_src, 0);

        // R4 pending request to disabled high-speed source
        set_sel(2);
        idle(200);
        check(active_src == 2'd0 && !busy, "R4 pending while disabled", active_src, 0);
        @(negedge ref_clk); osc_en[2] = 1;
        idle(200);
        check(active_src == 2'd0 && !busy, "R4 pending while unstable", active_src, 0);
        @(negedge ref_clk); osc_stable[2] = 1;
        wait_active(2, "R4 completes when stable");
        check_period(P_HIGH, "R6 high-speed period");
        idle(10);
        check(off_ok == 3'b011, "R7 off_ok after move to high", off_ok, 3);

        // R7 external use blocks permission
        @(negedge ref_clk); osc_ext_use[0] = 1;
        @(negedge ref_clk);
        check(off_ok == 3'b010, "R7 ext use blocks", off_ok, 2);
        @(negedge ref_clk); osc_ext_use[0] = 0;

        // R1 low-speed code and low-power flow
        @(negedge ref_clk); osc_en[1] = 1; osc_stable[1] = 1;
        idle(5);
        set_sel(1);
        wait_active(1, "R1 low-speed code");
        check_period(P_LOW, "R6 low-speed period");
        idle(10);
        check(off_ok == 3'b101, "R7 high may stop", off_ok, 5);
        set_sel(3);
        idle(300);
        check(active_src == 2'd1, "R3 reserved on low", active_src, 1);

        // stop high-speed, then return to internal
        @(negedge ref_clk); osc_en[2] = 0; osc_stable[2] = 0;
        set_sel(0);
        wait_active(0, "R1 internal code");
        check_period(P_INT, "R6 internal period");

        // R4 back to stopped high-speed stays pending
        set_sel(2);
        idle(300);
        check(active_src == 2'd0, "R4 stopped source refused", active_src, 0);
        set_sel(0);
        idle(20);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule